// File: doc/BRIEF.md
# Multidrop 9-bit Receive Address Filter

This block sits between a UART receiver and its receive buffer. Every received character comes with a ninth bit and a one-cycle valid strobe. When multidrop operation is enabled, that ninth bit marks the character as an address (1) or as data (0). The block decides which characters reach the buffer, and it keeps a gating flag that holds the node in an address-listening state until the node is selected.

The gating flag is a two-state machine. In LISTEN the flag reads 1, data characters are discarded and address characters are examined. In OPEN the flag reads 0 and characters flow through. There are four named transitions:
- HOST_ARM moves the machine to LISTEN on a host write of 1.
- HOST_OPEN moves it to OPEN on a host write of 0.
- ADDR_HIT moves LISTEN to OPEN when automatic addressing is on and an address character matches.
- ADDR_MISS moves OPEN to LISTEN when automatic addressing is on and an address character does not match.

An address character matches in either of two ways. It can match the node address, compared only where the mask is 1. It can also match the broadcast pattern, formed as node address OR mask: every bit set in that pattern must also be set in the received character. With multidrop disabled, every character passes unchanged.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset, `gate_flag` is 1 (LISTEN) and `out_valid` is 0.
- R2: With `cfg_mode_en`=0, every received character appears on `out_valid`/`out_data`/`out_tag` one cycle after its `rx_valid` cycle, with data and ninth bit unchanged.
- R3: With `cfg_mode_en`=1 and `gate_flag`=1, a character with `rx_tag`=0 (data) is not delivered.
- R4: With `cfg_mode_en`=1, `cfg_auto_en`=0 and `gate_flag`=1, a character with `rx_tag`=1 (address) is delivered and `gate_flag` is unchanged.
- R5: A cycle with `host_gate_wr`=1 sets `gate_flag` to `host_gate_val` on the next cycle. This host write takes priority over any hardware transition in the same cycle.
- R6: With automatic addressing on and `gate_flag`=1, an address character equal to `cfg_node_addr` on every bit where `cfg_node_mask` is 1 is delivered, and `gate_flag` becomes 0. A mask of all zeros matches any address.
- R7: With automatic addressing on and `gate_flag`=1, an address character that has a 1 on every bit where `cfg_node_addr | cfg_node_mask` is 1 is delivered, and `gate_flag` becomes 0.
- R8: With `cfg_mode_en`=1 and `gate_flag`=0, data characters are delivered.
- R9: With automatic addressing on and `gate_flag`=0, an address character that matches neither rule is dropped, and `gate_flag` becomes 1.
- R10: With automatic addressing on and `gate_flag`=1, a non-matching address character is dropped, and `gate_flag` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode_en | input | 1 | Multidrop (ninth bit as address tag) enable |
| cfg_auto_en | input | 1 | Hardware address matching enable |
| cfg_node_addr | input | 8 | Node address |
| cfg_node_mask | input | 8 | Node address mask |
| host_gate_wr | input | 1 | Host write strobe for the gating flag |
| host_gate_val | input | 1 | Value written to the gating flag |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character data |
| rx_tag | input | 1 | Received ninth bit (1 = address) |
| out_valid | output | 1 | Character delivered to buffer |
| out_data | output | 8 | Delivered data |
| out_tag | output | 1 | Delivered ninth bit |
| gate_flag | output | 1 | Gating flag (1 = LISTEN) |

## Verification
The hardest case to reach from the ports is a host write and a hardware transition in the same cycle. The bench makes it by raising `host_gate_wr` together with a matching address strobe, then checks that the host value wins. The other hard case is an address that misses the masked node-address compare but still hits the broadcast pattern. Configuration values were chosen so that the two rules give different answers, and each rule is probed on its own from LISTEN.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
    typedef enum logic [0:0] {
        GATE_OPEN   = 1'b0,
        GATE_LISTEN = 1'b1
    } gate_state_t;

    typedef enum logic [2:0] {
        MV_HOLD,
        MV_ADDR_HIT,
        MV_ADDR_MISS,
        MV_HOST_ARM,
        MV_HOST_OPEN
    } gate_move_t;
endpackage

// File: rtl/mdf_addr_match.sv
module mdf_addr_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] char_in,
    input  logic [DATA_W-1:0] node_addr,
    input  logic [DATA_W-1:0] node_mask,
    output logic              hit
);
    logic [DATA_W-1:0] given_ok;
    logic [DATA_W-1:0] bcast_ok;
    logic [DATA_W-1:0] bcast_pat;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // masked compare: mask 0 is don't-care
        assign given_ok[i]  = ~node_mask[i] | (char_in[i] == node_addr[i]);
        // broadcast: positions set in addr|mask must be 1
        assign bcast_pat[i] = node_addr[i] | node_mask[i];
        assign bcast_ok[i]  = ~bcast_pat[i] | char_in[i];
    end

    assign hit = (&given_ok) | (&bcast_ok);
endmodule

// File: rtl/mdf_gate_fsm.sv
module mdf_gate_fsm
    import mdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_en,
    input  logic        auto_en,
    input  logic        host_wr,
    input  logic        host_val,
    input  logic        rx_valid,
    input  logic        rx_tag,
    input  logic        hit,
    output gate_state_t state,
    output logic        gate_flag
);
    gate_state_t state_q, state_d;
    gate_move_t  move;
    logic        auto_addr_evt;

    assign auto_addr_evt = rx_valid & mode_en & auto_en & rx_tag;

    always_comb begin
        move = MV_HOLD;
        if (host_wr) begin
            move = host_val ? MV_HOST_ARM : MV_HOST_OPEN;
        end else if (auto_addr_evt) begin
            if (state_q == GATE_LISTEN && hit)
                move = MV_ADDR_HIT;
            else if (state_q == GATE_OPEN && !hit)
                move = MV_ADDR_MISS;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (move)
            MV_HOLD:      state_d = state_q;
            MV_ADDR_HIT:  state_d = GATE_OPEN;
            MV_ADDR_MISS: state_d = GATE_LISTEN;
            MV_HOST_ARM:  state_d = GATE_LISTEN;
            MV_HOST_OPEN: state_d = GATE_OPEN;
            default:      state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= GATE_LISTEN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state = state_q;
        unique case (state_q)
            GATE_LISTEN: gate_flag = 1'b1;
            GATE_OPEN:   gate_flag = 1'b0;
            default:     gate_flag = 1'b1;
        endcase
    end
endmodule

// File: rtl/mdf_deliver.sv
module mdf_deliver
    import mdf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              auto_en,
    input  gate_state_t       state,
    input  logic              hit,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_tag,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_tag
);
    logic pass;

    always_comb begin
        pass = 1'b1;
        if (mode_en) begin
            unique case (state)
                GATE_LISTEN: pass = rx_tag & (~auto_en | hit);
                GATE_OPEN:   pass = ~(auto_en & rx_tag & ~hit);
                default:     pass = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_tag   <= 1'b0;
        end else begin
            out_valid <= rx_valid & pass;
            if (rx_valid) begin
                out_data <= rx_data;
                out_tag  <= rx_tag;
            end
        end
    end
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
    import mdf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode_en,
    input  logic              cfg_auto_en,
    input  logic [DATA_W-1:0] cfg_node_addr,
    input  logic [DATA_W-1:0] cfg_node_mask,
    input  logic              host_gate_wr,
    input  logic              host_gate_val,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_tag,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_tag,
    output logic              gate_flag
);
    logic        hit;
    gate_state_t state;

    mdf_addr_match #(.DATA_W(DATA_W)) u_match (
        .char_in   (rx_data),
        .node_addr (cfg_node_addr),
        .node_mask (cfg_node_mask),
        .hit       (hit)
    );

    mdf_gate_fsm u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_en   (cfg_mode_en),
        .auto_en   (cfg_auto_en),
        .host_wr   (host_gate_wr),
        .host_val  (host_gate_val),
        .rx_valid  (rx_valid),
        .rx_tag    (rx_tag),
        .hit       (hit),
        .state     (state),
        .gate_flag (gate_flag)
    );

    mdf_deliver #(.DATA_W(DATA_W)) u_deliver (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_en   (cfg_mode_en),
        .auto_en   (cfg_auto_en),
        .state     (state),
        .hit       (hit),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_tag    (rx_tag),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_tag   (out_tag)
    );
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_mode_en,
    input logic              cfg_auto_en,
    input logic              host_gate_wr,
    input logic              host_gate_val,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_tag,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_tag,
    input logic              gate_flag
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gate_flag && !out_valid));

    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_mode_en) |=>
            (out_valid && out_data == $past(rx_data) && out_tag == $past(rx_tag)));

    assert_drop_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_mode_en && gate_flag && !rx_tag) |=> !out_valid);

    assert_manual_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_mode_en && !cfg_auto_en && gate_flag && rx_tag && !host_gate_wr)
            |=> (out_valid && gate_flag));

    assert_host_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_gate_wr |=> (gate_flag == $past(host_gate_val)));

    assert_open_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_mode_en && !gate_flag && !rx_tag) |=> out_valid);
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode_en   (cfg_mode_en),
    .cfg_auto_en   (cfg_auto_en),
    .host_gate_wr  (host_gate_wr),
    .host_gate_val (host_gate_val),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_tag        (rx_tag),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_tag       (out_tag),
    .gate_flag     (gate_flag)
);

// File: tb/mdrop_addr_filter_tb_top.sv
`timescale 1ns/1ps
module mdrop_addr_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode_en = 1'b0;
    logic       cfg_auto_en = 1'b0;
    logic [7:0] cfg_node_addr = 8'h00;
    logic [7:0] cfg_node_mask = 8'h00;
    logic       host_gate_wr = 1'b0;
    logic       host_gate_val = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_tag = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_tag;
    logic       gate_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mdrop_addr_filter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_mode_en   (cfg_mode_en),
        .cfg_auto_en   (cfg_auto_en),
        .cfg_node_addr (cfg_node_addr),
        .cfg_node_mask (cfg_node_mask),
        .host_gate_wr  (host_gate_wr),
        .host_gate_val (host_gate_val),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_tag        (rx_tag),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_tag       (out_tag),
        .gate_flag     (gate_flag)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present one character (optionally with a host write), then check one cycle later.
    task automatic send(string req, logic [7:0] d, logic t, logic wr, logic wv,
                        logic exp_v, logic exp_g);
        rx_valid = 1'b1; rx_data = d; rx_tag = t;
        host_gate_wr = wr; host_gate_val = wv;
        @(posedge clk); #1;
        rx_valid = 1'b0; host_gate_wr = 1'b0;
        check(req, "out_valid", int'(out_valid), int'(exp_v));
        if (exp_v) begin
            check(req, "out_data", int'(out_data), int'(d));
            check(req, "out_tag", int'(out_tag), int'(t));
        end
        check(req, "gate_flag", int'(gate_flag), int'(exp_g));
    endtask

    task automatic host_write(string req, logic v);
        host_gate_wr = 1'b1; host_gate_val = v;
        @(posedge clk); #1;
        host_gate_wr = 1'b0;
        check(req, "gate_flag", int'(gate_flag), int'(v));
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1", "gate_flag", int'(gate_flag), 1);
        check("R1", "out_valid", int'(out_valid), 0);
    endtask

    task automatic t_mode_off();
        cfg_mode_en = 1'b0; cfg_auto_en = 1'b0;
        send("R2", 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        send("R2", 8'h81, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_manual();
        cfg_mode_en = 1'b1; cfg_auto_en = 1'b0;
        send("R3", 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        send("R4", 8'h35, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        host_write("R5", 1'b0);
        send("R8", 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        host_write("R5", 1'b1);
        send("R3", 8'h23, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    // addr A5, mask F0: node rule matches Ax; broadcast pattern F5
    task automatic t_auto();
        cfg_mode_en = 1'b1; cfg_auto_en = 1'b1;
        cfg_node_addr = 8'hA5; cfg_node_mask = 8'hF0;
        send("R10", 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        send("R3",  8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        send("R6",  8'hA3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        send("R8",  8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        send("R9",  8'h35, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        send("R7",  8'hF7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        send("R9",  8'h0A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        send("R7",  8'hF5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        send("R8",  8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        send("R6",  8'hAF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_host_priority();
        host_write("R5", 1'b1);
        // matching address and host arm in the same cycle: host wins
        send("R5", 8'hA0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        host_write("R5", 1'b0);
        // non-matching address and host open together: stays open
        send("R5", 8'h35, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_zero_mask();
        cfg_node_addr = 8'h00; cfg_node_mask = 8'h00;
        host_write("R5", 1'b1);
        send("R6", 8'h12, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_mode_off();
        t_manual();
        t_auto();
        t_host_priority();
        t_zero_mask();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #50000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule